// File: doc/BRIEF.md
# Overlay memory access decoder

This decoder sits between a CPU with a 16-bit address bus and an overlay memory that shares the upper 16K of the address space with a system ROM. On every bus cycle it decides whether the ROM, the overlay RAM, a control-register write, or nothing at all is selected. It also chooses which of two RAM banks is used. The controller that owns the operating mode and the read, write and execute bank choices is outside this block and feeds them in. The same is true of the memory arrays and the I/O decoding.

Routing depends on more than the target address. It also depends on where the instruction that is currently executing was fetched from: the lower 48K (0x0000–0xBFFF) or the upper 16K (0xC000–0xFFFF). A small two-state machine keeps track of this. It takes the code region from address bits 15:14 on every opcode-fetch cycle (`sync` high) and holds it until the next fetch. An opcode fetch is itself routed by the region of its own address. When lower-region code stores to the top page, the store becomes a control-register write strobe, and the low data nibble is the command.

Region states: `EXEC_LOW` (the reset state) and `EXEC_HIGH`. Transitions: FETCH_LOW enters `EXEC_LOW` on a fetch below 0xC000. FETCH_HIGH enters `EXEC_HIGH` on a fetch at or above 0xC000. HOLD keeps the state when there is no fetch.

Top module: `ovl_access_decoder`

## Requirements
- R1: For addresses 0xFC00–0xFEFF, `rom_sel`, `ram_sel`, `ram_we` and `ctl_we` are all 0, in every mode and every code region.
- R2: For addresses below 0xC000, `rom_sel`, `ram_sel`, `ram_we` and `ctl_we` are all 0.
- R3: The mode encoding is 0 = ROM, 1 = ROM+RAM, 2 = RAM, and the reserved value 3 behaves as ROM. In ROM mode, a load (`rnw`=1) in 0xC000–0xFBFF sets `rom_sel` and a store (`rnw`=0) selects nothing.
- R4: In ROM+RAM mode, with lower-region code, accesses in 0xC000–0xFBFF select RAM. A load uses the read bank. A store sets `ram_we` and uses the write bank. Bank bit 0 is bank A and 1 is bank B.
- R5: In ROM+RAM mode, with upper-region code, a load in 0xC000–0xFBFF selects the ROM and a store selects nothing.
- R6: In RAM mode, in 0xC000–0xFBFF, a store selects RAM with `ram_we` and the write bank in either region. A data load uses the read bank. An opcode fetch uses the execute bank.
- R7: A store to 0xFF00–0xFFFF from lower-region code, in any mode, sets `ctl_we` with `ctl_cmd` equal to `data_lo`, and selects no RAM and no ROM. When `ctl_we` is 0, `ctl_cmd` is 0.
- R8: In ROM and ROM+RAM modes, every load in 0xFF00–0xFFFF selects the ROM, and a store from upper-region code selects nothing.
- R9: In RAM mode, in 0xFF00–0xFFFF, a load from lower-region code reads the execute bank. A load from upper-region code reads the read bank. A store from upper-region code writes the write bank.
- R10: The code region resets to lower. It is loaded from bits 15:14 on each `sync` cycle and held otherwise. A fetch cycle is routed by the region of its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset of the region tracker |
| addr | input | 16 | Bus address |
| rnw | input | 1 | 1 = load, 0 = store |
| sync | input | 1 | Opcode-fetch cycle indicator |
| data_lo | input | 4 | Low nibble of the write data bus |
| mode | input | 2 | Operating mode (0 ROM, 1 ROM+RAM, 2 RAM, 3 as ROM) |
| bank_rd | input | 1 | Read bank (0 A, 1 B) |
| bank_wr | input | 1 | Write bank |
| bank_ex | input | 1 | Execute bank |
| rom_sel | output | 1 | System ROM select |
| ram_sel | output | 1 | Overlay RAM select |
| ram_bank | output | 1 | Selected RAM bank, 0 when RAM is not selected |
| ram_we | output | 1 | Overlay RAM write enable |
| ctl_we | output | 1 | Control-register write strobe |
| ctl_cmd | output | 4 | Command nibble for the control register |

## Verification
The hardest case to reach is any access whose routing depends on the region of an earlier opcode fetch. It cannot be set up in the same cycle as the access, because the region comes from history. Each table vector is therefore preceded by one fetch cycle at 0x8000 or 0xE000, which places the tracker in the wanted region before the checked access. Directed sequences then hold the region across several cycles without a fetch, reset it while it is upper, and route a fetch on the top page by its own address.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [1:0] {
        MODE_ROM  = 2'd0,
        MODE_MIX  = 2'd1,
        MODE_RAM  = 2'd2,
        MODE_RSVD = 2'd3
    } ovl_mode_e;

    typedef enum logic {
        EXEC_LOW  = 1'b0,
        EXEC_HIGH = 1'b1
    } ovl_region_e;

    typedef enum logic [1:0] {
        TGT_BELOW  = 2'd0,
        TGT_WINDOW = 2'd1,
        TGT_IO     = 2'd2,
        TGT_TOP    = 2'd3
    } ovl_tgt_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic bank;
        logic we;
        logic ctl;
    } ovl_route_t;

endpackage

// File: rtl/ovl_region_tracker.sv
module ovl_region_tracker
    import ovl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync,
    input  logic [1:0]  addr_top,
    output ovl_region_e region
);

    ovl_region_e state_q;
    ovl_region_e state_d;
    ovl_region_e fetch_region;

    // Region named by the address of the current fetch
    always_comb begin
        fetch_region = (addr_top == 2'b11) ? EXEC_HIGH : EXEC_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EXEC_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // FETCH_LOW / FETCH_HIGH on sync, HOLD otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXEC_LOW: begin
                if (sync && fetch_region == EXEC_HIGH) begin
                    state_d = EXEC_HIGH;
                end
            end
            EXEC_HIGH: begin
                if (sync && fetch_region == EXEC_LOW) begin
                    state_d = EXEC_LOW;
                end
            end
        endcase
    end

    // A fetch cycle is routed by its own address
    always_comb begin
        region = sync ? fetch_region : state_q;
    end

endmodule

// File: rtl/ovl_target_classify.sv
module ovl_target_classify
    import ovl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic [ADDR_W-PAGE_W-1:0] page,
    output ovl_tgt_e                 tgt
);

    localparam int PG_W = ADDR_W - PAGE_W;
    localparam logic [PG_W-1:0] PAGE_TOP = '1;
    localparam logic [PG_W-1:0] PAGE_IO_LO = PAGE_TOP - PG_W'(3);

    always_comb begin
        if (page[PG_W-1 -: 2] != 2'b11) begin
            tgt = TGT_BELOW;
        end else if (page == PAGE_TOP) begin
            tgt = TGT_TOP;
        end else if (page >= PAGE_IO_LO) begin
            tgt = TGT_IO;
        end else begin
            tgt = TGT_WINDOW;
        end
    end

endmodule

// File: rtl/ovl_route_table.sv
module ovl_route_table
    import ovl_pkg::*;
(
    input  ovl_tgt_e    tgt,
    input  ovl_mode_e   mode,
    input  ovl_region_e region,
    input  logic        rnw,
    input  logic        sync,
    input  logic        bank_rd,
    input  logic        bank_wr,
    input  logic        bank_ex,
    output ovl_route_t  route
);

    always_comb begin
        route = '0;
        unique case (tgt)
            TGT_BELOW, TGT_IO: begin
                route = '0;
            end
            TGT_WINDOW: begin
                unique case (mode)
                    MODE_MIX: begin
                        if (region == EXEC_LOW) begin
                            route.ram  = 1'b1;
                            route.we   = !rnw;
                            route.bank = rnw ? bank_rd : bank_wr;
                        end else if (rnw) begin
                            route.rom = 1'b1;
                        end
                    end
                    MODE_RAM: begin
                        route.ram  = 1'b1;
                        route.we   = !rnw;
                        if (!rnw) begin
                            route.bank = bank_wr;
                        end else begin
                            route.bank = sync ? bank_ex : bank_rd;
                        end
                    end
                    MODE_ROM, MODE_RSVD: begin
                        route.rom = rnw;
                    end
                endcase
            end
            TGT_TOP: begin
                if (!rnw && region == EXEC_LOW) begin
                    route.ctl = 1'b1;
                end else if (mode == MODE_RAM) begin
                    route.ram = 1'b1;
                    route.we  = !rnw;
                    if (!rnw) begin
                        route.bank = bank_wr;
                    end else begin
                        route.bank = (region == EXEC_LOW) ? bank_ex : bank_rd;
                    end
                end else begin
                    route.rom = rnw;
                end
            end
        endcase
    end

endmodule

// File: rtl/ovl_access_decoder.sv
module ovl_access_decoder
    import ovl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              sync,
    input  logic [CMD_W-1:0]  data_lo,
    input  logic [1:0]        mode,
    input  logic              bank_rd,
    input  logic              bank_wr,
    input  logic              bank_ex,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              ram_bank,
    output logic              ram_we,
    output logic              ctl_we,
    output logic [CMD_W-1:0]  ctl_cmd
);

    localparam int PG_W = ADDR_W - PAGE_W;

    ovl_region_e region;
    ovl_tgt_e    tgt;
    ovl_route_t  route;
    ovl_mode_e   mode_e;

    always_comb begin
        mode_e = ovl_mode_e'(mode);
    end

    ovl_region_tracker u_region (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync     (sync),
        .addr_top (addr[ADDR_W-1 -: 2]),
        .region   (region)
    );

    ovl_target_classify #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_classify (
        .page (addr[ADDR_W-1 -: PG_W]),
        .tgt  (tgt)
    );

    ovl_route_table u_route (
        .tgt     (tgt),
        .mode    (mode_e),
        .region  (region),
        .rnw     (rnw),
        .sync    (sync),
        .bank_rd (bank_rd),
        .bank_wr (bank_wr),
        .bank_ex (bank_ex),
        .route   (route)
    );

    always_comb begin
        rom_sel  = route.rom;
        ram_sel  = route.ram;
        ram_bank = route.bank;
        ram_we   = route.we;
        ctl_we   = route.ctl;
        ctl_cmd  = route.ctl ? data_lo : '0;
    end

endmodule

// File: rtl/ovl_decoder_chk.sv
module ovl_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rnw,
    input logic              sync,
    input logic [1:0]        mode,
    input logic              rom_sel,
    input logic              ram_sel,
    input logic              ram_we,
    input logic              ctl_we
);

    localparam int PG_W = ADDR_W - PAGE_W;
    localparam logic [PG_W-1:0] PG_TOP = '1;

    logic [PG_W-1:0] pg;
    logic is_top, is_io, is_below, is_win;

    always_comb begin
        pg       = addr[ADDR_W-1 -: PG_W];
        is_top   = (pg == PG_TOP);
        is_io    = (pg == PG_TOP - PG_W'(1)) || (pg == PG_TOP - PG_W'(2)) ||
                   (pg == PG_TOP - PG_W'(3));
        is_below = (addr[ADDR_W-1 -: 2] != 2'b11);
        is_win   = !is_below && !is_top && !is_io;
    end

    assert_io_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_io |-> (!rom_sel && !ram_sel && !ram_we && !ctl_we));

    assert_below_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_below |-> (!rom_sel && !ram_sel && !ctl_we));

    assert_rom_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0 || mode == 2'd3) && is_win) |-> (!ram_sel && rom_sel == rnw));

    assert_ram_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && is_win && !rnw) |-> (ram_sel && ram_we));

    assert_we_is_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_sel && !rnw && !rom_sel));

    assert_ctl_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |-> (is_top && !rnw && !ram_sel && !rom_sel));

    assert_top_rom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2 && is_top && rnw) |-> rom_sel);

    assert_top_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && is_top && rnw) |-> (ram_sel && !rom_sel));

    assert_region_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sync) && $past(addr[ADDR_W-1 -: 2]) == 2'b11 &&
         !sync && !rnw && is_top) |-> !ctl_we);

    assert_region_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sync) && $past(addr[ADDR_W-1 -: 2]) != 2'b11 &&
         !sync && !rnw && is_top) |-> ctl_we);

endmodule

bind ovl_access_decoder ovl_decoder_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rnw     (rnw),
    .sync    (sync),
    .mode    (mode),
    .rom_sel (rom_sel),
    .ram_sel (ram_sel),
    .ram_we  (ram_we),
    .ctl_we  (ctl_we)
);

// File: tb/test_ovl_access_decoder.sv
module test_ovl_access_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rnw = 1'b1;
    logic        sync = 1'b0;
    logic [3:0]  data_lo = '0;
    logic [1:0]  mode = '0;
    logic        bank_rd = 1'b0;
    logic        bank_wr = 1'b0;
    logic        bank_ex = 1'b0;
    logic        rom_sel, ram_sel, ram_bank, ram_we, ctl_we;
    logic [3:0]  ctl_cmd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ovl_access_decoder i_ovl_access_decoder (
        .clk (clk), .rst_n (rst_n), .addr (addr), .rnw (rnw), .sync (sync),
        .data_lo (data_lo), .mode (mode), .bank_rd (bank_rd), .bank_wr (bank_wr),
        .bank_ex (bank_ex), .rom_sel (rom_sel), .ram_sel (ram_sel),
        .ram_bank (ram_bank), .ram_we (ram_we), .ctl_we (ctl_we), .ctl_cmd (ctl_cmd)
    );

    typedef struct packed {
        logic        hi;
        logic [1:0]  md;
        logic [15:0] a;
        logic        rd_n_wr;
        logic        sy;
        logic        brd, bwr, bex;
        logic [3:0]  d;
        logic        e_rom, e_ram, e_bank, e_we, e_ctl;
        logic [3:0]  e_cmd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    // fields: code region, mode, addr, rnw, sync, rd/wr/ex bank, data,
    //         expected rom, ram, bank, we, ctl, cmd, requirement number
    localparam vec_t VT [NV] = '{
        '{0,0,16'hC123,1,0,0,0,0,4'h0, 1,0,0,0,0,4'h0, 3},  // R3 load
        '{0,0,16'hC123,0,0,0,0,0,4'h0, 0,0,0,0,0,4'h0, 3},  // R3 store ignored
        '{0,3,16'hD000,1,0,1,1,1,4'h0, 1,0,0,0,0,4'h0, 3},  // R3 reserved mode
        '{0,1,16'hC200,1,0,1,0,0,4'h0, 0,1,1,0,0,4'h0, 4},  // R4 read bank
        '{0,1,16'hF000,0,0,1,0,1,4'h0, 0,1,0,1,0,4'h0, 4},  // R4 write bank
        '{1,1,16'hC200,1,0,1,0,0,4'h0, 1,0,0,0,0,4'h0, 5},  // R5 load rom
        '{1,1,16'hE000,0,0,1,1,1,4'h0, 0,0,0,0,0,4'h0, 5},  // R5 store ignored
        '{1,2,16'hC400,1,0,1,0,0,4'h0, 0,1,1,0,0,4'h0, 6},  // R6 upper load
        '{0,2,16'hFBFF,0,0,0,1,0,4'h0, 0,1,1,1,0,4'h0, 6},  // R6 lower store
        '{0,2,16'hC800,1,1,0,0,1,4'h0, 0,1,1,0,0,4'h0, 6},  // R6 fetch exec bank
        '{1,2,16'hC000,0,0,1,0,1,4'h0, 0,1,0,1,0,4'h0, 6},  // R6 upper store
        '{0,0,16'hFF00,0,0,0,0,0,4'hA, 0,0,0,0,1,4'hA, 7},  // R7 rom mode
        '{0,2,16'hFFFF,0,0,1,1,1,4'h5, 0,0,0,0,1,4'h5, 7},  // R7 ram mode
        '{0,1,16'hFFFC,1,0,1,1,1,4'h0, 1,0,0,0,0,4'h0, 8},  // R8 vector from rom
        '{1,0,16'hFF10,0,0,0,0,0,4'h3, 0,0,0,0,0,4'h0, 8},  // R8 upper store rom
        '{1,1,16'hFF80,0,0,1,1,1,4'h2, 0,0,0,0,0,4'h0, 8},  // R8 upper store mix
        '{0,2,16'hFFFE,1,0,0,0,1,4'h0, 0,1,1,0,0,4'h0, 9},  // R9 lower load ex
        '{1,2,16'hFF20,1,0,1,0,0,4'h0, 0,1,1,0,0,4'h0, 9},  // R9 upper load rd
        '{1,2,16'hFF40,0,0,0,1,0,4'h6, 0,1,1,1,0,4'h0, 9},  // R9 upper store wr
        '{0,2,16'hFC00,1,0,1,1,1,4'h0, 0,0,0,0,0,4'h0, 1},  // R1
        '{0,2,16'hFEFF,0,0,1,1,1,4'h9, 0,0,0,0,0,4'h0, 1},  // R1
        '{1,0,16'hFD55,1,0,0,0,0,4'h0, 0,0,0,0,0,4'h0, 1},  // R1
        '{0,2,16'hBFFF,1,0,1,1,1,4'h0, 0,0,0,0,0,4'h0, 2},  // R2
        '{0,2,16'h0000,0,0,1,1,1,4'h7, 0,0,0,0,0,4'h0, 2},  // R2
        '{0,2,16'hFF30,1,1,1,0,0,4'h0, 0,1,1,0,0,4'h0, 10}  // R10 own-address fetch
    };

    task automatic check(input string tag, input logic [8:0] exp);
        logic [8:0] act;
        act = {rom_sel, ram_sel, ram_bank, ram_we, ctl_we, ctl_cmd};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%h act=%b exp=%b", tag, addr, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [15:0] a, input logic r,
                         input logic s, input logic [3:0] d);
        mode = m; addr = a; rnw = r; sync = s; data_lo = d;
    endtask

    task automatic fetch(input logic hi, input logic [1:0] m);
        @(negedge clk);
        drive(m, hi ? 16'hE000 : 16'h8000, 1'b1, 1'b1, 4'h0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R10: region is lower, so a top-page store is a command
        drive(2'd1, 16'hFF00, 1'b0, 1'b0, 4'h2);
        #2 check("R10 region during reset", 9'b00001_0010);
        rst_n = 1'b1;
        @(negedge clk);
        drive(2'd1, 16'hFF00, 1'b0, 1'b0, 4'hC);
        #2 check("R10 reset region lower", 9'b00001_1100);

        for (int i = 0; i < NV; i++) begin
            fetch(VT[i].hi, VT[i].md);
            @(negedge clk);
            drive(VT[i].md, VT[i].a, VT[i].rd_n_wr, VT[i].sy, VT[i].d);
            bank_rd = VT[i].brd; bank_wr = VT[i].bwr; bank_ex = VT[i].bex;
            #2 check($sformatf("R%0d vector %0d", VT[i].req, i),
                     {VT[i].e_rom, VT[i].e_ram, VT[i].e_bank, VT[i].e_we,
                      VT[i].e_ctl, VT[i].e_cmd});
        end

        // R10: upper region holds across cycles without fetch
        bank_rd = 1'b0; bank_wr = 1'b1; bank_ex = 1'b0;
        fetch(1'b1, 2'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive(2'd1, 16'hC010, 1'b1, 1'b0, 4'h0);
        end
        #2 check("R10 hold upper load", 9'b10000_0000);
        @(negedge clk);
        drive(2'd1, 16'hFF00, 1'b0, 1'b0, 4'h8);
        #2 check("R10 hold upper no command", 9'b00000_0000);
        // R10: a lower fetch returns the region
        fetch(1'b0, 2'd1);
        @(negedge clk);
        drive(2'd1, 16'hFF00, 1'b0, 1'b0, 4'h8);
        #2 check("R10 back to lower", 9'b00001_1000);
        // R10: reset clears an upper region
        fetch(1'b1, 2'd2);
        @(negedge clk);
        drive(2'd2, 16'hFF50, 1'b0, 1'b0, 4'h4);
        #2 check("R10 upper store RAM", 9'b01110_0000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2 check("R10 after reset lower", 9'b00001_0100);
        // R7: the command follows the data nibble combinationally
        data_lo = 4'hF;
        #1 check("R7 command tracks data", 9'b00001_1111);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule